// File: doc/BRIEF.md
# Truncated pipelined CIC decimator

This block lowers the sample rate of a multi-bit sigma-delta modulator stream by a fixed factor of sixteen, with no multiplier. It is a fifth-order cascaded integrator-comb filter. Five integrators run at the input rate and advance only on cycles where the input strobe is high. A down-sampler keeps every sixteenth accumulated value. Five first-difference combs then run at the decimated rate and produce a 16-bit result with its own one-cycle strobe.

The first integrator is wide enough for the full growth of a fifth-order, rate-16 filter on a 5-bit input. To save area and adder delay, each following integrator keeps only the upper part of the previous stage's word. The integrator chain is pipelined through its own accumulators, so each stage adds the previous stage's registered value. No register is added for this, and the longest path is one adder.

Top module: `cic_trunc_decim`

## Requirements
- R1: The input `in_data` is a 5-bit two's-complement sample. It is accepted on every rising edge where `in_valid` is high and `rst` is low, and is sign-extended to 25 bits before the first integrator adds it.
- R2: The five integrator registers are 25, 22, 20, 18 and 16 bits wide. Stage 1 adds the sign-extended sample. Stages 2 to 5 each add the upper bits of the previous stage's accumulator value as it stood before the current accepted sample: bits [24:3], [21:2], [19:2] and [17:2] respectively.
- R3: Every integrator and comb addition or subtraction wraps modulo 2^width with no saturation. Long runs of full-scale constant input (+15 or -16) still yield the exactly wrapped result.
- R4: On cycles with `in_valid` low, no integrator, phase or comb state changes.
- R5: A phase counter, cleared by reset, counts accepted samples modulo 16. Exactly one decimated value is taken per 16 accepted samples: the stage-5 accumulator value just after the 16th, 32nd, ... accepted sample.
- R6: `out_valid` is high for exactly one cycle, two rising edges after the edge that accepts the 16th sample of a group.
- R7: `out_data` changes only on cycles where `out_valid` is high and holds its value in between.
- R8: A synchronous, active-high `rst` clears all integrators, combs, the phase counter, `out_valid` and `out_data` to zero. Samples presented while it is high are ignored.
- R9: Each of the five combs is 16 bits wide and outputs its current decimated input minus its input one decimated sample earlier (differential delay 1). `out_data` is the fifth comb's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the input sample rate |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 5 | Two's-complement input sample |
| out_valid | output | 1 | One-cycle strobe per decimated result |
| out_data | output | 16 | Decimated filter output |

## Verification
On every cycle, the assertions check the following:
- the single-cycle output strobe;
- its exact placement two edges after every sixteenth accepted sample, and nowhere else;
- the frozen integrator output on idle cycles;
- `out_data` holding between strobes;
- the cleared state after reset.

Only the bench's scenarios can show that the numbers are right. The bench compares the outputs against a bit-accurate model of the truncated, pipelined cascade, across four kinds of input:
- zero input;
- full-scale constants that force many wraps;
- alternating extremes;
- random data with random gaps.

It also covers samples ignored during a reset that falls in the middle of a group.

// File: rtl/cic_pkg.sv
package cic_pkg;
  // Width of one entry in a packed per-stage width list.
  localparam int WFIELD = 8;

  function automatic int stage_w(input logic [63:0] wlist, input int k);
    return int'(wlist[k*WFIELD +: WFIELD]);
  endfunction
endpackage

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int          IN_W   = 5,
  parameter int          NSTAGE = 5,
  parameter logic [63:0] WLIST  = {24'd0, 8'd16, 8'd18, 8'd20, 8'd22, 8'd25},
  parameter int          OUT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce,
  input  logic signed [IN_W-1:0]  in_data,
  output logic [OUT_W-1:0]        last_acc
);
  import cic_pkg::*;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    localparam int W = stage_w(WLIST, k);
    logic signed [W-1:0] acc;
    logic signed [W-1:0] addend;

    if (k == 0) begin : g_first
      assign addend = W'(in_data);
    end else begin : g_next
      localparam int PW = stage_w(WLIST, k-1);
      // registered value of the previous stage, low bits dropped
      assign addend = signed'(g_stage[k-1].acc[PW-1 -: W]);
    end

    always_ff @(posedge clk) begin
      if (rst)     acc <= '0;
      else if (ce) acc <= acc + addend;
    end
  end

  assign last_acc = g_stage[NSTAGE-1].acc;
endmodule

// File: rtl/cic_phase.sv
module cic_phase #(
  parameter int RATE_LOG2 = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  output logic dec_stb
);
  localparam logic [RATE_LOG2-1:0] LAST = '1;
  logic [RATE_LOG2-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      dec_stb <= 1'b0;
    end else begin
      dec_stb <= ce && (phase == LAST);
      if (ce) phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int NSTAGE = 5,
  parameter int W      = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stb,
  input  logic [W-1:0] din,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic [NSTAGE:0][W-1:0] tap;
  assign tap[0] = din;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_comb
    logic [W-1:0] dly;
    assign tap[k+1] = tap[k] - dly;
    always_ff @(posedge clk) begin
      if (rst)      dly <= '0;
      else if (stb) dly <= tap[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= stb;
      if (stb) out_data <= tap[NSTAGE];
    end
  end
endmodule

// File: rtl/cic_trunc_decim.sv
module cic_trunc_decim #(
  parameter int          IN_W      = 5,
  parameter int          NSTAGE    = 5,
  parameter int          RATE_LOG2 = 4,
  parameter logic [63:0] WLIST     = {24'd0, 8'd16, 8'd18, 8'd20, 8'd22, 8'd25},
  parameter int          OUT_W     = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_data,
  output logic                   out_valid,
  output logic [OUT_W-1:0]       out_data
);
  logic [OUT_W-1:0] last_acc;
  logic             dec_stb;

  cic_integ_chain #(.IN_W(IN_W), .NSTAGE(NSTAGE), .WLIST(WLIST), .OUT_W(OUT_W)) u_integ (
    .clk(clk), .rst(rst), .ce(in_valid), .in_data(in_data), .last_acc(last_acc)
  );

  cic_phase #(.RATE_LOG2(RATE_LOG2)) u_phase (
    .clk(clk), .rst(rst), .ce(in_valid), .dec_stb(dec_stb)
  );

  cic_comb_chain #(.NSTAGE(NSTAGE), .W(OUT_W)) u_comb (
    .clk(clk), .rst(rst), .stb(dec_stb), .din(last_acc),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/cic_trunc_decim_chk.sv
module cic_trunc_decim_chk #(
  parameter int RATE_LOG2 = 4,
  parameter int OUT_W     = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic [OUT_W-1:0] last_acc
);
  localparam logic [RATE_LOG2-1:0] LAST = '1;
  logic [RATE_LOG2-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (in_valid) cnt <= cnt + 1'b1;
  end

  // R6: strobe lasts one cycle
  p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R5: the 16th accepted sample yields a strobe two edges later
  p_group_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cnt == LAST) |=> ##1 out_valid);

  // R5: no strobe without a completed group
  p_only_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && cnt == LAST, 2));

  // R4: idle cycles freeze the integrators
  p_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(last_acc));

  // R7: output data holds between strobes
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  // R8: reset clears outputs and integrators
  p_clear_r8: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0 && last_acc == '0));
endmodule

bind cic_trunc_decim cic_trunc_decim_chk #(.RATE_LOG2(RATE_LOG2), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data), .last_acc(last_acc)
);

// File: tb/cic_trunc_decim_bench.sv
`timescale 1ns/100ps
module cic_trunc_decim_bench;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic signed [4:0] in_data = '0;
  logic              out_valid;
  logic [15:0]       out_data;

  always #2.5 clk = ~clk;

  cic_trunc_decim u_cic_trunc_decim (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string tag   = "R1";

  // reference model state (R1, R2, R3, R9)
  logic [24:0] m1;
  logic [21:0] m2;
  logic [19:0] m3;
  logic [17:0] m4;
  logic [15:0] m5;
  logic [15:0] md [5];
  int          mph;
  logic [15:0] exp_q [$];
  realtime     exp_t [$];
  logic [15:0] last_out;

  task automatic model_clear();
    m1 = '0; m2 = '0; m3 = '0; m4 = '0; m5 = '0; mph = 0;
    for (int i = 0; i < 5; i++) md[i] = '0;
    exp_q.delete(); exp_t.delete();
    last_out = '0;
  endtask

  function automatic logic [15:0] comb_step(input logic [15:0] s);
    logic [15:0] c, t;
    c = s;
    for (int i = 0; i < 5; i++) begin
      t = c - md[i];
      md[i] = c;
      c = t;
    end
    return c;
  endfunction

  task automatic model_step(input logic signed [4:0] x, input realtime t_drv);
    logic [24:0] n1; logic [21:0] n2; logic [19:0] n3; logic [17:0] n4; logic [15:0] n5;
    n1 = m1 + {{20{x[4]}}, x};
    n2 = m2 + m1[24:3];
    n3 = m3 + m2[21:2];
    n4 = m4 + m3[19:2];
    n5 = m5 + m4[17:2];
    m1 = n1; m2 = n2; m3 = n3; m4 = n4; m5 = n5;
    mph = (mph + 1) % 16;
    if (mph == 0) begin
      exp_q.push_back(comb_step(m5));
      exp_t.push_back(t_drv + 11.5);
    end
  endtask

  task automatic report(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          report(1'b0, "R5", "unexpected output strobe", 1, 0);
        end else begin
          logic [15:0] e;
          realtime     et;
          e  = exp_q.pop_front();
          et = exp_t.pop_front();
          report(out_data == e, tag, "output value", out_data, e);
          report($realtime == et, "R6", "output time (x10ns)",
                 longint'($realtime*10), longint'(et*10));
        end
        last_out = out_data;
      end else begin
        // R7: data holds between strobes
        report(out_data == last_out, "R7", "held output", out_data, last_out);
      end
    end
  end

  task automatic drive(input bit v, input logic signed [4:0] x);
    @(posedge clk);
    #1;
    in_valid = v;
    in_data  = x;
    if (v && !rst) model_step(x, $realtime);
  endtask

  task automatic do_reset(input int cycles);
    @(posedge clk);
    #1;
    rst = 1'b1;
    for (int i = 0; i < cycles; i++) drive(1'b1, 5'sd7); // R8: ignored
    @(posedge clk);
    #1;
    rst = 1'b0;
    in_valid = 1'b0;
    model_clear();
    @(negedge clk);
    report(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
    report(out_data == 16'd0, "R8", "out_data after reset", out_data, 0);
  endtask

  initial begin
    #(200000 * 5);
    report(1'b0, "R5", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'h00C1C516));
    model_clear();
    do_reset(3);

    tag = "R1";   // zero input gives zero output
    for (int i = 0; i < 64; i++) drive(1'b1, 5'sd0);

    tag = "R3";   // full-scale positive constant, many wraps
    for (int i = 0; i < 480; i++) drive(1'b1, 5'sd15);
    tag = "R3";   // full-scale negative constant
    for (int i = 0; i < 480; i++) drive(1'b1, -5'sd16);

    tag = "R9";   // alternating extremes stress the combs
    for (int i = 0; i < 320; i++) drive(1'b1, (i % 2) ? -5'sd16 : 5'sd15);

    tag = "R2";   // random data, every cycle valid
    for (int i = 0; i < 1600; i++) drive(1'b1, 5'($urandom));

    tag = "R4";   // random data with random idle gaps
    for (int i = 0; i < 3000; i++) drive(($urandom % 10) < 6, 5'($urandom));

    // R8: reset inside a group, then the phase must restart
    for (int i = 0; i < 7; i++) drive(1'b1, 5'sd9);
    do_reset(4);
    tag = "R5";
    for (int i = 0; i < 400; i++) drive(($urandom % 4) != 0, 5'($urandom));

    drive(1'b0, 5'sd0);
    repeat (6) @(posedge clk);
    @(negedge clk);
    report(exp_q.size() == 0, "R5", "outstanding results", exp_q.size(), 0);
    finish_run();
  end
endmodule